// File: doc/BRIEF.md
# Sector Write-Lockout Guard

This block holds one write-protect bit for each of 22 erase sectors and rules on every program, erase and lock request before it reaches the array sequencer. Sectors 0 to 7 make up the small-sector plane and sectors 8 to 21 the large-sector plane. The guard answers every request with exactly one single-cycle `grant_o` or `deny_o` pulse. Protection cannot be removed by any command. A high-voltage override input bypasses it only while that input is held.

A lock request waits a programmed settle interval before its bit takes effect. A sector erase aimed at a protected sector does not fail at once: the guard stays busy for a short abort interval and then denies. A chip erase is always granted, and with the grant the guard supplies a mask of the sectors the sequencer must leave alone. In identification mode a read port reports the protect bit of any sector. The bits model non-volatile storage, so only the power-on clear input resets them. The ordinary reset leaves them untouched.

Top module: `sector_lock_guard`

## Requirements
- R1: There are 22 protect bits, one per sector (sector i is bit i). They start clear after `por_ni` goes low and are never cleared by `rst_ni`.
- R2: A lock request (kind 2'b11) to a valid sector raises `busy_o` for LOCK_CYC cycles, starting the cycle after the request. It then sets that sector's bit and pulses `grant_o`.
- R3: A word program (kind 2'b00) is answered in the cycle after the request, without `busy_o`. It gets `grant_o` if the sector is unprotected and `deny_o` if the sector is protected and the override is low.
- R4: A sector erase (kind 2'b01) to a protected sector with the override low raises `busy_o` for ABORT_CYC cycles and then pulses `deny_o`. No bit changes.
- R5: A sector erase to an unprotected sector is granted in the cycle after the request.
- R6: While `hv_override_i` is high, program and sector erase requests to protected sectors are granted in the cycle after the request.
- R7: Once `hv_override_i` falls, the next request to a protected sector is refused again.
- R8: A chip erase (kind 2'b10) is granted in the cycle after the request. With the grant, `erase_mask_o` holds the protect bits when the override is low and all zeros when it is high. Every other grant drives the mask to zero.
- R9: `id_data_o` bit 0 equals the protect bit of `id_sector_i` when `id_offset_i` is 2. Otherwise, and for an invalid sector, it is 0. All other bits are 0.
- R10: A program, sector erase or lock request with a sector index of 22 or more is denied in the cycle after the request and changes no bit.
- R11: Requests presented while `busy_o` is high are ignored and produce no pulse.
- R12: `grant_o` and `deny_o` are never high together, and each accepted request yields exactly one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low async reset of control state |
| por_ni | input | 1 | Active-low async power-on clear of protect bits |
| hv_override_i | input | 1 | High-voltage override, bypasses protection while high |
| req_valid_i | input | 1 | Request strobe, one cycle |
| req_kind_i | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 lock |
| req_sector_i | input | 5 | Decoded sector index |
| id_sector_i | input | 5 | Sector for identification read |
| id_offset_i | input | 2 | Word offset within sector for identification read |
| id_data_o | output | 16 | Identification read data |
| busy_o | output | 1 | Abort or lock interval in progress |
| grant_o | output | 1 | Request permitted pulse |
| deny_o | output | 1 | Request refused pulse |
| erase_mask_o | output | 22 | Sectors a chip erase must skip |

## Verification
The bench targets the timing split between refusals. A protected word program must be refused the next cycle with no busy time, while a protected sector erase must hold busy for the full abort interval first. A design that merged the two paths would show busy on a program or a premature deny on an erase. It also checks that protection survives the ordinary reset and the override window and returns the moment the override drops; a guard that cleared bits on the wrong reset, or latched the override, would grant a refused request. Chip erase masks are compared with the override both low and high, and out-of-range indices and requests made during busy are checked for stray pulses or bit changes.

// File: rtl/sector_lock_pkg.sv
package sector_lock_pkg;
  typedef enum logic [1:0] {
    REQ_PROG   = 2'd0,
    REQ_SERASE = 2'd1,
    REQ_CERASE = 2'd2,
    REQ_LOCK   = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ABORT,
    ST_LOCKWAIT
  } guard_state_e;

  typedef enum logic [1:0] {
    DEC_GRANT,
    DEC_DENY,
    DEC_ABORT,
    DEC_LOCK
  } decision_e;
endpackage

// File: rtl/sector_lock_bank.sv
module sector_lock_bank #(
  parameter int N  = 22,
  parameter int SW = 5
) (
  input  logic          clk_i,
  input  logic          por_ni,
  input  logic          set_en_i,
  input  logic [SW-1:0] set_idx_i,
  output logic [N-1:0]  lock_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni)                                  lock_o[i] <= 1'b0;
      else if (set_en_i && set_idx_i == SW'(i))     lock_o[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/sector_lock_gate.sv
module sector_lock_gate
  import sector_lock_pkg::*;
#(
  parameter int N  = 22,
  parameter int SW = 5
) (
  input  req_kind_e     kind_i,
  input  logic [SW-1:0] sector_i,
  input  logic [N-1:0]  lock_i,
  input  logic          override_i,
  output decision_e     dec_o
);
  logic valid, locked;

  always_comb begin
    valid  = (int'(sector_i) < N);
    locked = 1'b0;
    for (int i = 0; i < N; i++)
      if (sector_i == SW'(i)) locked = lock_i[i];
  end

  always_comb begin
    if (kind_i == REQ_CERASE)           dec_o = DEC_GRANT;
    else if (!valid)                    dec_o = DEC_DENY;
    else if (kind_i == REQ_LOCK)        dec_o = DEC_LOCK;
    else if (locked && !override_i)     dec_o = (kind_i == REQ_SERASE) ? DEC_ABORT : DEC_DENY;
    else                                dec_o = DEC_GRANT;
  end
endmodule

// File: rtl/sector_lock_timer.sv
module sector_lock_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sector_lock_guard.sv
module sector_lock_guard
  import sector_lock_pkg::*;
#(
  parameter  int N           = 22,
  parameter  int LOCK_CYC    = 20000,
  parameter  int ABORT_CYC   = 200,
  parameter  int DW          = 16,
  parameter  int OW          = 2,
  parameter  int ID_LOCK_OFF = 2,
  localparam int SW          = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          por_ni,
  input  logic          hv_override_i,
  input  logic          req_valid_i,
  input  logic [1:0]    req_kind_i,
  input  logic [SW-1:0] req_sector_i,
  input  logic [SW-1:0] id_sector_i,
  input  logic [OW-1:0] id_offset_i,
  output logic [DW-1:0] id_data_o,
  output logic          busy_o,
  output logic          grant_o,
  output logic          deny_o,
  output logic [N-1:0]  erase_mask_o
);
  localparam int MAXC = (LOCK_CYC > ABORT_CYC) ? LOCK_CYC : ABORT_CYC;
  localparam int TW   = $clog2(MAXC + 1);

  guard_state_e  state_q;
  decision_e     dec;
  req_kind_e     kind;
  logic [N-1:0]  lock_q;
  logic [SW-1:0] pend_q;
  logic          fire, tmr_zero, tmr_load, set_en, id_lock;
  logic [TW-1:0] tmr_val;

  assign kind     = req_kind_e'(req_kind_i);
  assign fire     = req_valid_i && (state_q == ST_IDLE);
  assign tmr_load = fire && (dec == DEC_ABORT || dec == DEC_LOCK);
  assign tmr_val  = (dec == DEC_ABORT) ? TW'(ABORT_CYC - 1) : TW'(LOCK_CYC - 1);
  assign set_en   = (state_q == ST_LOCKWAIT) && tmr_zero;

  sector_lock_gate #(.N(N), .SW(SW)) u_gate (
    .kind_i    (kind),
    .sector_i  (req_sector_i),
    .lock_i    (lock_q),
    .override_i(hv_override_i),
    .dec_o     (dec)
  );

  sector_lock_bank #(.N(N), .SW(SW)) u_bank (
    .clk_i    (clk_i),
    .por_ni   (por_ni),
    .set_en_i (set_en),
    .set_idx_i(pend_q),
    .lock_o   (lock_q)
  );

  sector_lock_timer #(.W(TW)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .zero_o    (tmr_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      pend_q       <= '0;
      grant_o      <= 1'b0;
      deny_o       <= 1'b0;
      erase_mask_o <= '0;
    end else begin
      grant_o <= 1'b0;
      deny_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (fire) begin
          unique case (dec)
            DEC_GRANT: begin
              grant_o      <= 1'b1;
              erase_mask_o <= (kind == REQ_CERASE && !hv_override_i) ? lock_q : '0;
            end
            DEC_DENY:  deny_o  <= 1'b1;
            DEC_ABORT: state_q <= ST_ABORT;
            DEC_LOCK: begin
              state_q <= ST_LOCKWAIT;
              pend_q  <= req_sector_i;
            end
          endcase
        end
        ST_ABORT: if (tmr_zero) begin
          state_q <= ST_IDLE;
          deny_o  <= 1'b1;
        end
        ST_LOCKWAIT: if (tmr_zero) begin
          state_q      <= ST_IDLE;
          grant_o      <= 1'b1;
          erase_mask_o <= '0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);

  always_comb begin
    id_lock = 1'b0;
    for (int i = 0; i < N; i++)
      if (id_sector_i == SW'(i)) id_lock = lock_q[i];
  end

  assign id_data_o = {{(DW-1){1'b0}}, id_lock && (id_offset_i == OW'(ID_LOCK_OFF))};
endmodule

// File: rtl/sector_lock_guard_chk.sv
module sector_lock_guard_chk #(
  parameter int N = 22
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         por_ni,
  input logic         hv_override_i,
  input logic         req_valid_i,
  input logic [1:0]   req_kind_i,
  input logic         busy_o,
  input logic         grant_o,
  input logic         deny_o,
  input logic [N-1:0] erase_mask_o,
  input logic [N-1:0] lock_q
);
  p_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    !(grant_o && deny_o));

  p_busy_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    busy_o |-> !(grant_o || deny_o));

  p_lock_sticky_r1: assert property (@(posedge clk_i) disable iff (!por_ni)
    1'b1 |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

  p_mask_subset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    grant_o |-> ((erase_mask_o & ~lock_q) == '0));

  p_override_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (req_valid_i && !busy_o && req_kind_i == 2'b10 && hv_override_i)
      |=> (grant_o && erase_mask_o == '0));

  p_prog_fast_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (req_valid_i && !busy_o && req_kind_i == 2'b00) |=> (!busy_o && (grant_o ^ deny_o)));
endmodule

bind sector_lock_guard sector_lock_guard_chk #(.N(N)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .por_ni       (por_ni),
  .hv_override_i(hv_override_i),
  .req_valid_i  (req_valid_i),
  .req_kind_i   (req_kind_i),
  .busy_o       (busy_o),
  .grant_o      (grant_o),
  .deny_o       (deny_o),
  .erase_mask_o (erase_mask_o),
  .lock_q       (lock_q)
);

// File: tb/tb_sector_lock_guard.sv
module tb_sector_lock_guard;
  localparam int L = 12;
  localparam int A = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b0, ovr = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic [4:0]  req_sector = '0, id_sector = '0;
  logic [1:0]  id_offset = '0;
  logic [15:0] id_data_o;
  logic        busy_o, grant_o, deny_o;
  logic [21:0] erase_mask_o;

  int nchk = 0, nfail = 0, cyc = 0, pulses = 0;

  typedef struct {
    bit          g;
    logic [21:0] m;
    int          c;
    string       t;
  } exp_t;
  exp_t q[$];
  exp_t e;

  sector_lock_guard #(.LOCK_CYC(L), .ABORT_CYC(A)) dut (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .hv_override_i(ovr),
    .req_valid_i(req_valid), .req_kind_i(req_kind), .req_sector_i(req_sector),
    .id_sector_i(id_sector), .id_offset_i(id_offset), .id_data_o(id_data_o),
    .busy_o(busy_o), .grant_o(grant_o), .deny_o(deny_o), .erase_mask_o(erase_mask_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pop expected item on every pulse
  always @(negedge clk) begin
    if (rst_n && por_n && (grant_o || deny_o)) begin
      pulses++;
      nchk++;
      if (q.size() == 0) begin
        nfail++;
        $display("FAIL R12 unexpected pulse: grant=%0b deny=%0b, expected none", grant_o, deny_o);
      end else begin
        e = q.pop_front();
        if (grant_o != e.g || deny_o != !e.g || cyc != e.c || (e.g && erase_mask_o != e.m)) begin
          nfail++;
          $display("FAIL %s: grant=%0b deny=%0b cyc=%0d mask=%h, expected grant=%0b cyc=%0d mask=%h",
                   e.t, grant_o, deny_o, cyc, erase_mask_o, e.g, e.c, e.m);
        end
      end
    end
  end

  task automatic check(input bit ok, input string t, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] k, input logic [4:0] s, input bit g,
                       input logic [21:0] m, input int lat, input string t);
    int nb;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_sector = s;
    q.push_back('{g, m, cyc + 1 + lat, t});
    @(negedge clk);
    req_valid = 1'b0;
    nb = 0;
    for (int i = 0; i <= lat; i++) begin
      if (busy_o) nb++;
      @(negedge clk);
    end
    check(nb == lat, {t, " busy cycles"}, nb, lat);
    check(q.size() == 0, {t, " response seen"}, q.size(), 0);
  endtask

  task automatic chk_id(input logic [4:0] s, input logic [1:0] off, input bit exp, input string t);
    @(negedge clk);
    id_sector = s; id_offset = off;
    #1;
    check(id_data_o == {15'b0, exp}, t, int'(id_data_o), int'(exp));
  endtask

  initial begin
    #(200000 * 10);
    nfail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    check(!grant_o && !deny_o && !busy_o, "R1 reset outputs idle", int'({grant_o, deny_o, busy_o}), 0);
    chk_id(5'd3, 2'd2, 1'b0, "R1 bits clear after power-on clear");
    @(negedge clk); por_n = 1'b1; rst_n = 1'b1;

    issue(2'b00, 5'd3, 1'b1, '0, 0, "R3 program unlocked");
    issue(2'b01, 5'd3, 1'b1, '0, 0, "R5 erase unlocked");
    issue(2'b10, 5'd0, 1'b1, '0, 0, "R8 chip erase no locks");

    issue(2'b11, 5'd3, 1'b1, '0, L, "R2 lock sector 3");
    chk_id(5'd3, 2'd2, 1'b1, "R9 lock status sector 3");
    chk_id(5'd3, 2'd0, 1'b0, "R9 other offset reads 0");
    chk_id(5'd4, 2'd2, 1'b0, "R9 unlocked sector 4");

    issue(2'b00, 5'd3, 1'b0, '0, 0, "R3 program locked denied");
    issue(2'b01, 5'd3, 1'b0, '0, A, "R4 erase locked aborts");
    issue(2'b11, 5'd21, 1'b1, '0, L, "R2 lock sector 21");
    issue(2'b10, 5'd0, 1'b1, 22'h200008, 0, "R8 chip erase skip mask");

    @(negedge clk); ovr = 1'b1;
    issue(2'b00, 5'd3, 1'b1, '0, 0, "R6 program with override");
    issue(2'b01, 5'd21, 1'b1, '0, 0, "R6 erase with override");
    issue(2'b10, 5'd0, 1'b1, '0, 0, "R8 chip erase override mask");
    @(negedge clk); ovr = 1'b0;
    issue(2'b00, 5'd3, 1'b0, '0, 0, "R7 lock back after override");

    issue(2'b00, 5'd22, 1'b0, '0, 0, "R10 program invalid sector");
    issue(2'b11, 5'd25, 1'b0, '0, 0, "R10 lock invalid sector");
    chk_id(5'd22, 2'd2, 1'b0, "R10 invalid sector status");
    issue(2'b10, 5'd0, 1'b1, 22'h200008, 0, "R10 locks unchanged");

    // R11: program offered while abort is running must be ignored
    p0 = pulses;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b01; req_sector = 5'd3;
    q.push_back('{1'b0, '0, cyc + 1 + A, "R11 abort with request during busy"});
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk); req_valid = 1'b1; req_kind = 2'b00; req_sector = 5'd5;
    @(negedge clk); req_valid = 1'b0;
    repeat (A + 3) @(negedge clk);
    check(pulses - p0 == 1, "R11 one pulse only", pulses - p0, 1);
    check(q.size() == 0, "R11 queue drained", q.size(), 0);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(!busy_o && !grant_o && !deny_o, "R1 rst outputs idle", int'({grant_o, deny_o, busy_o}), 0);
    rst_n = 1'b1;
    chk_id(5'd3, 2'd2, 1'b1, "R1 lock survives rst");
    issue(2'b00, 5'd21, 1'b0, '0, 0, "R1 lock 21 enforced after rst");
    @(negedge clk); por_n = 1'b0;
    chk_id(5'd3, 2'd2, 1'b0, "R1 power-on clear");
    @(negedge clk); por_n = 1'b1;
    issue(2'b00, 5'd3, 1'b1, '0, 0, "R1 program after power-on clear");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule